// File: doc/BRIEF.md
# Interrupt CPU Interface Unit

This unit is the processor-facing half of an interrupt controller. A distributor, which is not part of this block, presents one candidate at a time. The candidate is an interrupt ID, the number of the CPU that raised it, and an 8-bit priority. The unit decides whether that candidate may interrupt the core. To do so it checks the candidate against a programmable priority mask and against the priority of the handler that is running now. When the candidate passes, the unit raises a request line to the core.

Software drives the unit through a small word-addressed register window:

- A read of the acknowledge register claims the winning interrupt. The unit pushes that interrupt onto a stack of active handlers and sends an acknowledge pulse to the distributor.
- A write of the same ID to the end-of-interrupt register retires the handler on top of the stack. The unit sends a deactivate pulse and the previous running priority comes back.
- A peek register reports the current winner without taking it.

Nesting is decided only on the group part of the priority. A binary-point field sets where the priority splits into a group part and a subpriority part.

Top module: `icu_cpu_if`

## Requirements
- R1: After reset the control, mask and binary-point registers read 0, the running priority reads 0xFF, the peek register reads 1023 and the request line is low.
- R2: The request is high only when control bit 0 is set, a candidate is valid, its priority is numerically strictly below the mask, the active stack is not full and the group test of R3 passes.
- R3: With binary point b, only priority bits above bit b form the group priority. When a handler is active, a candidate passes only if its group priority is numerically strictly below the group priority of the running priority. When no handler is active, the group test always passes.
- R4: A read of the acknowledge register (offset 0x0C) while the request is high does three things. It returns the ID in bits [9:0] and the CPU number in bits [12:10], and the CPU number is forced to 0 for IDs of 16 and above. It pushes the interrupt as active. One cycle later it gives a one-cycle acknowledge pulse carrying the ID.
- R5: A read of the acknowledge register while nothing qualifies returns 1023, pushes nothing and gives no pulse.
- R6: A read of the peek register (offset 0x18) returns the same word format as R4, or 1023 when nothing qualifies, and changes no state.
- R7: A write to the end-of-interrupt register (offset 0x10) whose bits [9:0] match the top active ID pops that entry. One cycle later it gives a one-cycle deactivate pulse carrying the ID, and the running priority returns to the previous entry.
- R8: An end-of-interrupt write whose ID is not the top active ID has no effect, and gives no pulse.
- R9: The running-priority register (offset 0x14) reads 0xFF when the stack is empty, and otherwise the priority of the top entry.
- R10: While the active stack holds DEPTH entries, no candidate is signalled and an acknowledge read returns 1023.
- R11: The mask register (offset 0x04) keeps write bits [7:0] and the binary point (offset 0x08) keeps bits [2:0]. The identification register (offset 0xFC) reads the IDENT parameter, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cand_valid | input | 1 | Distributor presents a pending candidate |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_cpu | input | 3 | Requesting CPU of the candidate |
| cand_prio | input | 8 | Candidate priority, lower is more urgent |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid during the read cycle |
| irq_out | output | 1 | Interrupt request to the core |
| ack_pulse | output | 1 | Acknowledge pulse to the distributor |
| ack_id | output | 10 | ID acknowledged |
| deact_pulse | output | 1 | Deactivate pulse to the distributor |
| deact_id | output | 10 | ID deactivated |

## Verification
The hardest case to reach is a candidate that is numerically more urgent than the running handler but falls in the same priority group, so it must not preempt. The stimulus sets a non-zero binary point and acknowledges a first interrupt so that it becomes the running priority. It then presents a candidate that differs only in subpriority, followed by one a group higher. Filling the active stack to its depth needs four nested acknowledges with priorities that fall group by group. The stack is then drained in reverse order, with one out-of-order end-of-interrupt placed in between to check that it is ignored.

// File: rtl/icu_pkg.sv
package icu_pkg;
   // Register offsets; software decodes these, so they are fixed.
   localparam int OFF_CTRL = 'h00;
   localparam int OFF_PMSK = 'h04;
   localparam int OFF_BPT  = 'h08;
   localparam int OFF_ACK  = 'h0C;
   localparam int OFF_EOI  = 'h10;
   localparam int OFF_RUN  = 'h14;
   localparam int OFF_PEEK = 'h18;
   localparam int OFF_IDNT = 'hFC;

   localparam int DEF_ID_W   = 10;
   localparam int DEF_CPU_W  = 3;
   localparam int DEF_PRIO_W = 8;
   localparam int DEF_BP_W   = 3;
   localparam int SPUR_ID    = 1023;
   localparam int SGI_LIMIT  = 16;
endpackage

// File: rtl/icu_cfg_regs.sv
module icu_cfg_regs #(
   parameter int PRIO_W = 8,
   parameter int BP_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic              wr_pmsk,
   input  logic              wr_bpt,
   input  logic [PRIO_W-1:0] wdata_lo,
   output logic              en_q,
   output logic [PRIO_W-1:0] pmsk_q,
   output logic [BP_W-1:0]   bpt_q
);
   if (BP_W > PRIO_W) begin : g_bad_bp
      $error("binary point field wider than priority");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         pmsk_q <= '0;
         bpt_q  <= '0;
      end else begin
         if (wr_ctrl) en_q   <= wdata_lo[0];
         if (wr_pmsk) pmsk_q <= wdata_lo;
         if (wr_bpt)  bpt_q  <= wdata_lo[BP_W-1:0];
      end
   end

   // R11
   bpt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_bpt |=> (bpt_q == $past(wdata_lo[BP_W-1:0])));
endmodule

// File: rtl/icu_active_stack.sv
module icu_active_stack #(
   parameter int DEPTH  = 4,
   parameter int ID_W   = 10,
   parameter int PRIO_W = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ID_W-1:0]   push_id,
   input  logic [PRIO_W-1:0] push_prio,
   input  logic              pop,
   output logic [ID_W-1:0]   top_id,
   output logic [PRIO_W-1:0] top_prio,
   output logic              empty,
   output logic              full,
   output logic [CNT_W-1:0]  count
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("stack depth must be at least one");
   end

   logic [ID_W-1:0]   ids   [DEPTH];
   logic [PRIO_W-1:0] prios [DEPTH];
   logic [CNT_W-1:0]  wr_slot;

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign wr_slot = pop ? count - 1'b1 : count;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ids[g]   <= '0;
            prios[g] <= '0;
         end else if (push && wr_slot == CNT_W'(g)) begin
            ids[g]   <= push_id;
            prios[g] <= push_prio;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            count <= '0;
      else if (push && !pop) count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
   end

   always_comb begin
      top_id   = '0;
      top_prio = '1;
      for (int i = 0; i < DEPTH; i++) begin
         if (count == CNT_W'(i + 1)) begin
            top_id   = ids[i];
            top_prio = prios[i];
         end
      end
   end

   // R10
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |-> !full);
   // R7
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/icu_prio_gate.sv
module icu_prio_gate #(
   parameter int PRIO_W = 8,
   parameter int BP_W   = 3
) (
   input  logic              en,
   input  logic              cand_valid,
   input  logic [PRIO_W-1:0] cand_prio,
   input  logic [PRIO_W-1:0] pmsk,
   input  logic [BP_W-1:0]   bpt,
   input  logic [PRIO_W-1:0] run_prio,
   input  logic              stk_empty,
   input  logic              stk_full,
   output logic              eligible
);
   logic [PRIO_W-1:0] gmask;
   logic              grp_ok;

   always_comb begin
      for (int i = 0; i < PRIO_W; i++) gmask[i] = (i > int'(bpt));
   end

   assign grp_ok   = stk_empty || ((cand_prio & gmask) < (run_prio & gmask));
   assign eligible = en && cand_valid && !stk_full && (cand_prio < pmsk) && grp_ok;
endmodule

// File: rtl/icu_cpu_if.sv
module icu_cpu_if
   import icu_pkg::*;
#(
   parameter int          ID_W    = DEF_ID_W,
   parameter int          CPU_W   = DEF_CPU_W,
   parameter int          PRIO_W  = DEF_PRIO_W,
   parameter int          BP_W    = DEF_BP_W,
   parameter int          ADDR_W  = 8,
   parameter int          DEPTH   = 4,
   parameter bit          REG_IRQ = 1'b0,
   parameter logic [31:0] IDENT   = 32'h0002_0A5C,
   localparam int         CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cand_valid,
   input  logic [ID_W-1:0]   cand_id,
   input  logic [CPU_W-1:0]  cand_cpu,
   input  logic [PRIO_W-1:0] cand_prio,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq_out,
   output logic              ack_pulse,
   output logic [ID_W-1:0]   ack_id,
   output logic              deact_pulse,
   output logic [ID_W-1:0]   deact_id
);
   if (ID_W < 10 || ID_W + CPU_W > 32) begin : g_bad_fmt
      $error("ID and CPU fields must fit the 32-bit word");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("address must reach offset 0xFC");
   end

   logic sel_ctrl, sel_pmsk, sel_bpt, sel_ack, sel_eoi, sel_run, sel_peek, sel_idnt;
   assign sel_ctrl = (reg_addr == ADDR_W'(OFF_CTRL));
   assign sel_pmsk = (reg_addr == ADDR_W'(OFF_PMSK));
   assign sel_bpt  = (reg_addr == ADDR_W'(OFF_BPT));
   assign sel_ack  = (reg_addr == ADDR_W'(OFF_ACK));
   assign sel_eoi  = (reg_addr == ADDR_W'(OFF_EOI));
   assign sel_run  = (reg_addr == ADDR_W'(OFF_RUN));
   assign sel_peek = (reg_addr == ADDR_W'(OFF_PEEK));
   assign sel_idnt = (reg_addr == ADDR_W'(OFF_IDNT));

   logic              en_q;
   logic [PRIO_W-1:0] pmsk_q;
   logic [BP_W-1:0]   bpt_q;

   icu_cfg_regs #(.PRIO_W(PRIO_W), .BP_W(BP_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctrl  (reg_wr && sel_ctrl),
      .wr_pmsk  (reg_wr && sel_pmsk),
      .wr_bpt   (reg_wr && sel_bpt),
      .wdata_lo (reg_wdata[PRIO_W-1:0]),
      .en_q     (en_q),
      .pmsk_q   (pmsk_q),
      .bpt_q    (bpt_q)
   );

   logic              push, pop, stk_empty, stk_full, eligible;
   logic [ID_W-1:0]   top_id;
   logic [PRIO_W-1:0] top_prio, run_prio;
   logic [CNT_W-1:0]  stk_count;

   icu_active_stack #(.DEPTH(DEPTH), .ID_W(ID_W), .PRIO_W(PRIO_W)) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_id   (cand_id),
      .push_prio (cand_prio),
      .pop       (pop),
      .top_id    (top_id),
      .top_prio  (top_prio),
      .empty     (stk_empty),
      .full      (stk_full),
      .count     (stk_count)
   );

   assign run_prio = stk_empty ? '1 : top_prio;

   icu_prio_gate #(.PRIO_W(PRIO_W), .BP_W(BP_W)) u_gate (
      .en         (en_q),
      .cand_valid (cand_valid),
      .cand_prio  (cand_prio),
      .pmsk       (pmsk_q),
      .bpt        (bpt_q),
      .run_prio   (run_prio),
      .stk_empty  (stk_empty),
      .stk_full   (stk_full),
      .eligible   (eligible)
   );

   // Handshakes with side effects
   assign push = reg_rd && sel_ack && eligible;
   assign pop  = reg_wr && sel_eoi && !stk_empty && (reg_wdata[ID_W-1:0] == top_id);

   logic unused_wdata;
   assign unused_wdata = ^reg_wdata[31:ID_W];

   // Read word for the current winner
   logic              is_sw;
   logic [CPU_W-1:0]  cpu_f;
   logic [31:0]       win_word;
   assign is_sw    = (cand_id < ID_W'(SGI_LIMIT));
   assign cpu_f    = is_sw ? cand_cpu : '0;
   assign win_word = eligible ? (32'(cand_id) | (32'(cpu_f) << ID_W)) : 32'(SPUR_ID);

   always_comb begin
      reg_rdata = '0;
      if (sel_ctrl)      reg_rdata = 32'(en_q);
      else if (sel_pmsk) reg_rdata = 32'(pmsk_q);
      else if (sel_bpt)  reg_rdata = 32'(bpt_q);
      else if (sel_ack)  reg_rdata = win_word;
      else if (sel_run)  reg_rdata = 32'(run_prio);
      else if (sel_peek) reg_rdata = win_word;
      else if (sel_idnt) reg_rdata = IDENT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_pulse   <= 1'b0;
         ack_id      <= '0;
         deact_pulse <= 1'b0;
         deact_id    <= '0;
      end else begin
         ack_pulse   <= push;
         deact_pulse <= pop;
         if (push) ack_id   <= cand_id;
         if (pop)  deact_id <= top_id;
      end
   end

   if (REG_IRQ) begin : g_reg_irq
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_out <= 1'b0;
         else        irq_out <= eligible;
      end
   end else begin : g_comb_irq
      assign irq_out = eligible;
   end

   // R4
   ack_sets_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_pulse |-> (run_prio == $past(cand_prio)));
   // R7
   deact_pops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      deact_pulse |-> (32'(stk_count) + 1 == 32'($past(stk_count))));
   // R2
   mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eligible |-> (en_q && cand_prio < pmsk_q));
   // R5
   spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && sel_ack && !eligible) |=> !ack_pulse);
endmodule

// File: tb/icu_cpu_if_test.sv
module icu_cpu_if_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cand_valid = 1'b0;
   logic [9:0]  cand_id = '0;
   logic [2:0]  cand_cpu = '0;
   logic [7:0]  cand_prio = '0;
   logic [7:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_out, ack_pulse, deact_pulse;
   logic [9:0]  ack_id, deact_id;

   int nchk = 0;
   int nfail = 0;

   always #4 clk = ~clk;

   icu_cpu_if uut (
      .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_id(cand_id),
      .cand_cpu(cand_cpu), .cand_prio(cand_prio), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_out(irq_out), .ack_pulse(ack_pulse),
      .ack_id(ack_id), .deact_pulse(deact_pulse), .deact_id(deact_id)
   );

   typedef struct packed {
      logic       en;
      logic [7:0] pmsk;
      logic       vld;
      logic [7:0] prio;
      logic       exp_irq;
   } vec_t;

   localparam vec_t VECS [0:7] = '{
      {1'b1, 8'hF0, 1'b1, 8'h10, 1'b1},
      {1'b1, 8'h10, 1'b1, 8'h10, 1'b0},
      {1'b1, 8'h11, 1'b1, 8'h10, 1'b1},
      {1'b0, 8'hFF, 1'b1, 8'h00, 1'b0},
      {1'b1, 8'hFF, 1'b1, 8'hFE, 1'b1},
      {1'b1, 8'hFF, 1'b0, 8'h00, 1'b0},
      {1'b1, 8'h00, 1'b1, 8'h00, 1'b0},
      {1'b1, 8'h80, 1'b1, 8'h7F, 1'b1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic cand(input logic v, input logic [9:0] id, input logic [2:0] cpu, input logic [7:0] p);
      cand_valid = v; cand_id = id; cand_cpu = cpu; cand_prio = p;
      #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      logic [31:0] d;
      cand(1'b1, 10'd40, 3'd0, 8'h00);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(8'h00, d); chk("R1 ctrl", d, 32'h0);
      rd(8'h04, d); chk("R1 mask", d, 32'h0);
      rd(8'h08, d); chk("R1 bpt", d, 32'h0);
      rd(8'h14, d); chk("R1 running", d, 32'hFF);
      rd(8'h18, d); chk("R1 peek", d, 32'd1023);
      chk("R1 irq", 32'(irq_out), 32'h0);

      // R2 table walk, empty stack
      for (int i = 0; i < 8; i++) begin
         wr(8'h00, 32'(VECS[i].en));
         wr(8'h04, 32'(VECS[i].pmsk));
         cand(VECS[i].vld, 10'(40 + i), 3'd3, VECS[i].prio);
         chk("R2 irq", 32'(irq_out), 32'(VECS[i].exp_irq));
         rd(8'h18, d);
         chk("R6 peek", d, VECS[i].exp_irq ? 32'(40 + i) : 32'd1023);
      end

      // R3/R4 nesting on group bits, binary point 2 -> group mask 0xF8
      wr(8'h00, 32'h1);
      wr(8'h04, 32'hFF);
      wr(8'h08, 32'h2);
      cand(1'b1, 10'd50, 3'd5, 8'h44);
      rd(8'h0C, d);
      chk("R4 ack word non-sw cpu zero", d, 32'd50);
      chk("R4 ack pulse", 32'(ack_pulse), 32'h1);
      chk("R4 ack id", 32'(ack_id), 32'd50);
      rd(8'h14, d); chk("R9 running after ack", d, 32'h44);
      chk("R4 pulse single", 32'(ack_pulse), 32'h0);
      cand(1'b1, 10'd51, 3'd0, 8'h41);
      chk("R3 same group no preempt", 32'(irq_out), 32'h0);
      cand(1'b1, 10'd5, 3'd5, 8'h3F);
      chk("R3 higher group preempts", 32'(irq_out), 32'h1);
      rd(8'h0C, d);
      chk("R4 ack word sw cpu", d, 32'h1405);
      rd(8'h14, d); chk("R9 nested running", d, 32'h3F);

      // R6 peek leaves state alone
      wr(8'h08, 32'h0);
      cand(1'b1, 10'd60, 3'd0, 8'h10);
      rd(8'h18, d); chk("R6 peek first", d, 32'd60);
      chk("R6 no ack pulse", 32'(ack_pulse), 32'h0);
      rd(8'h18, d); chk("R6 peek again", d, 32'd60);
      rd(8'h14, d); chk("R6 running unchanged", d, 32'h3F);
      cand(1'b0, 10'd0, 3'd0, 8'h00);

      // R8 out-of-order EOI ignored
      wr(8'h10, 32'd50);
      chk("R8 no deact pulse", 32'(deact_pulse), 32'h0);
      rd(8'h14, d); chk("R8 running kept", d, 32'h3F);
      // R7 matching EOI pops
      wr(8'h10, 32'd5);
      chk("R7 deact pulse", 32'(deact_pulse), 32'h1);
      chk("R7 deact id", 32'(deact_id), 32'd5);
      rd(8'h14, d); chk("R7 running restored", d, 32'h44);
      wr(8'h10, 32'd50);
      rd(8'h14, d); chk("R9 idle running", d, 32'hFF);

      // R5 spurious
      rd(8'h0C, d); chk("R5 spurious id", d, 32'd1023);
      chk("R5 no ack pulse", 32'(ack_pulse), 32'h0);
      rd(8'h14, d); chk("R5 running unchanged", d, 32'hFF);

      // R10 fill stack to depth 4
      for (int k = 0; k < 4; k++) begin
         cand(1'b1, 10'(100 + k), 3'd0, 8'(8'h80 - 8'(k * 32)));
         rd(8'h0C, d); chk("R10 fill ack", d, 32'(100 + k));
      end
      cand(1'b1, 10'd110, 3'd0, 8'h02);
      chk("R10 full no irq", 32'(irq_out), 32'h0);
      rd(8'h0C, d); chk("R10 full spurious", d, 32'd1023);
      cand(1'b0, 10'd0, 3'd0, 8'h00);
      for (int k = 3; k >= 0; k--) begin
         wr(8'h10, 32'(100 + k));
         chk("R7 drain deact id", 32'(deact_id), 32'(100 + k));
      end
      rd(8'h14, d); chk("R9 drained", d, 32'hFF);

      // R2 disabled interface
      wr(8'h00, 32'h0);
      cand(1'b1, 10'd70, 3'd0, 8'h01);
      chk("R2 disabled irq", 32'(irq_out), 32'h0);
      rd(8'h0C, d); chk("R2 disabled ack spurious", d, 32'd1023);

      // R11 field widths and identification
      wr(8'h04, 32'h0000_1234); rd(8'h04, d); chk("R11 mask width", d, 32'h34);
      wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, d); chk("R11 bpt width", d, 32'h7);
      rd(8'hFC, d); chk("R11 ident", d, 32'h0002_0A5C);
      rd(8'h40, d); chk("R11 unmapped", d, 32'h0);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule